// File: doc/BRIEF.md
# Task Operand Reservation Table

This block sits beside one processing element and parks tasks that have been dispatched to it but cannot start yet because some of their input operands are still being computed elsewhere. Each of its slots holds one task: the reorder tag that the task carries through the machine, and up to eight operand positions. An operand position is either ready, in which case its 32-bit word is the operand itself, or waiting, in which case the same word carries the tag of the task that will produce it.

The dispatcher first fills a slot through a single addressed write port, one operand field per cycle, and then claims the slot with an allocation pulse. Result broadcasts from finished tasks are compared against every waiting operand. A matching operand captures the broadcast word and turns ready. A slot whose operands are all ready is offered to the processing element. When several slots qualify, the one claimed earliest is offered first. The element accepts an offer with a take pulse and later reports completion, which frees the slot. A count of free slots is provided for the dispatcher.

Top module: `task_rsv_table`

## Requirements
- R1: While and after reset, all slots are free: `free_cnt` equals the slot count (4) and `issue_vld` is 0.
- R2: The write address is `{slot[5:4], field[3], operand[2:0]}`. Field 0 writes the status of the operand: `wr_data[8:1]` is its parameter ID and `wr_data[0]` is its ready flag (1 = ready).
- R3: Field 1 writes the 32-bit word of the operand. When the slot is offered, operand k appears on `issue_vals[32k+31:32k]` and its parameter ID on `issue_pids[8k+7:8k]`.
- R4: On a broadcast (`wk_en`), every waiting operand whose word has its low 6 bits equal to `wk_tag` takes `wk_data` and becomes ready. A ready operand is never changed by a broadcast, even if its low bits equal the tag.
- R5: A slot is offered (`issue_vld`) only when it is claimed, not yet taken, and all eight operands are ready. The offer appears in the cycle after the edge on which the last operand became ready, and carries the slot index and the tag given at allocation.
- R6: If several slots can be offered, the one claimed by the earliest `alloc_en` is offered.
- R7: After `issue_take` during an offer, that slot is never offered again. The next qualifying slot is offered in the following cycle.
- R8: `alloc_en` claims a slot and lowers `free_cnt` by one. `done_en` frees the named slot and raises `free_cnt` by one.
- R9: When a broadcast wakes an operand in the same cycle as a write to that operand, the broadcast wins. The operand ends ready and holds `wk_data`. A status write still updates the parameter ID.
- R10: An offer stays on the same slot while it is not taken and no write, broadcast, allocation or completion takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Addressed write strobe |
| wr_addr | input | 6 | Slot, field select and operand index |
| wr_data | input | 32 | Status bits or operand word |
| alloc_en | input | 1 | Claim a slot for a dispatched task |
| alloc_entry | input | 2 | Slot being claimed |
| alloc_tag | input | 6 | Reorder tag of the claimed task |
| wk_en | input | 1 | Result broadcast valid |
| wk_tag | input | 6 | Tag of the finished producer |
| wk_data | input | 32 | Broadcast result word |
| issue_vld | output | 1 | A slot is offered to the element |
| issue_entry | output | 2 | Offered slot |
| issue_tag | output | 6 | Reorder tag of the offered task |
| issue_vals | output | 256 | Operand words of the offered task |
| issue_pids | output | 64 | Parameter IDs of the offered task |
| issue_take | input | 1 | The element accepts the offer |
| done_en | input | 1 | The element has finished a task |
| done_entry | input | 2 | Slot to free |
| free_cnt | output | 3 | Number of free slots |

## Verification
The bench builds the table with its default parameters: four slots, eight operands, 32-bit words and 6-bit tags. With four slots it can fill the table, so `free_cnt` reaches zero, and it can build a three-way age race where the oldest slot waits and becomes ready last. With eight operands the highest word position, 7, is exercised for both waiting and ready operands. The 6-bit tag lets a ready operand whose low bits equal a broadcast tag show that a ready operand is left alone.

// File: rtl/trt_pkg.sv
package trt_pkg;
  // Field select carried in the write address
  typedef enum logic {
    FLD_STAT = 1'b0,
    FLD_VAL  = 1'b1
  } fld_sel_e;

  // Position of the ready flag inside a status write
  localparam int STAT_RDY_BIT = 0;
endpackage

// File: rtl/trt_entry.sv
module trt_entry #(
  parameter int N_OPND = 8,
  parameter int DATA_W = 32,
  parameter int TAG_W  = 6,
  parameter int PID_W  = 8,
  localparam int OPI_W = $clog2(N_OPND)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_stat_en,
  input  logic                     wr_val_en,
  input  logic [OPI_W-1:0]         wr_idx,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic                     wk_en,
  input  logic [TAG_W-1:0]         wk_tag,
  input  logic [DATA_W-1:0]        wk_data,
  output logic                     all_rdy,
  output logic [N_OPND*DATA_W-1:0] vals,
  output logic [N_OPND*PID_W-1:0]  pids
);
  logic [N_OPND-1:0] rdy_vec;

  for (genvar g = 0; g < N_OPND; g++) begin : g_opnd
    logic              rdy_q, rdy_d;
    logic [PID_W-1:0]  pid_q, pid_d;
    logic [DATA_W-1:0] val_q, val_d;
    logic              sel, hit, upd;

    assign sel = (wr_idx == OPI_W'(g));
    // waiting operand keeps the producer tag in the low bits of its word
    assign hit = wk_en && !rdy_q && (val_q[TAG_W-1:0] == wk_tag);
    assign upd = hit || (sel && (wr_stat_en || wr_val_en));

    always_comb begin
      rdy_d = rdy_q;
      pid_d = pid_q;
      val_d = val_q;
      if (sel && wr_stat_en) begin
        pid_d = wr_data[PID_W:1];
        rdy_d = wr_data[trt_pkg::STAT_RDY_BIT];
      end
      if (sel && wr_val_en) val_d = wr_data;
      if (hit) begin
        rdy_d = 1'b1;
        val_d = wk_data;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rdy_q <= 1'b0;
        pid_q <= '0;
        val_q <= '0;
      end else if (upd) begin
        rdy_q <= rdy_d;
        pid_q <= pid_d;
        val_q <= val_d;
      end
    end

    assign rdy_vec[g]              = rdy_q;
    assign vals[g*DATA_W +: DATA_W] = val_q;
    assign pids[g*PID_W +: PID_W]   = pid_q;
  end

  assign all_rdy = &rdy_vec;
endmodule

// File: rtl/trt_age_pick.sv
module trt_age_pick #(
  parameter int N = 4,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_en,
  input  logic [IDX_W-1:0] alloc_idx,
  input  logic [N-1:0]     cand,
  output logic             pick_vld,
  output logic [IDX_W-1:0] pick_idx
);
  // older_q[i][j] set: slot i was claimed before slot j
  logic [N-1:0][N-1:0] older_q, older_d;
  logic [N-1:0]        win;

  always_comb begin
    older_d = older_q;
    for (int j = 0; j < N; j++) begin
      if (j != int'(alloc_idx)) begin
        older_d[alloc_idx][j] = 1'b0;
        older_d[j][alloc_idx] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        older_q <= '0;
    else if (alloc_en) older_q <= older_d;
  end

  always_comb begin
    pick_vld = 1'b0;
    pick_idx = '0;
    for (int i = 0; i < N; i++) begin
      win[i] = cand[i];
      for (int j = 0; j < N; j++) begin
        if (j != i && cand[j] && older_q[j][i]) win[i] = 1'b0;
      end
      if (win[i]) begin
        pick_vld = 1'b1;
        pick_idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/task_rsv_table.sv
module task_rsv_table #(
  parameter int ENTRIES = 4,
  parameter int N_OPND  = 8,
  parameter int DATA_W  = 32,
  parameter int TAG_W   = 6,
  parameter int PID_W   = 8,
  localparam int ENT_W  = $clog2(ENTRIES),
  localparam int OPI_W  = $clog2(N_OPND),
  localparam int ADDR_W = ENT_W + 1 + OPI_W,
  localparam int CNT_W  = $clog2(ENTRIES + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic                     alloc_en,
  input  logic [ENT_W-1:0]         alloc_entry,
  input  logic [TAG_W-1:0]         alloc_tag,
  input  logic                     wk_en,
  input  logic [TAG_W-1:0]         wk_tag,
  input  logic [DATA_W-1:0]        wk_data,
  output logic                     issue_vld,
  output logic [ENT_W-1:0]         issue_entry,
  output logic [TAG_W-1:0]         issue_tag,
  output logic [N_OPND*DATA_W-1:0] issue_vals,
  output logic [N_OPND*PID_W-1:0]  issue_pids,
  input  logic                     issue_take,
  input  logic                     done_en,
  input  logic [ENT_W-1:0]         done_entry,
  output logic [CNT_W-1:0]         free_cnt
);
  import trt_pkg::*;

  logic [ENT_W-1:0] wr_ent;
  fld_sel_e         wr_sel;
  logic [OPI_W-1:0] wr_idx;

  assign wr_ent = wr_addr[ADDR_W-1 -: ENT_W];
  assign wr_sel = fld_sel_e'(wr_addr[OPI_W]);
  assign wr_idx = wr_addr[OPI_W-1:0];

  logic [ENTRIES-1:0]                    rdy_a;
  logic [ENTRIES-1:0][N_OPND*DATA_W-1:0] vals_a;
  logic [ENTRIES-1:0][N_OPND*PID_W-1:0]  pids_a;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    logic hit_ent;
    assign hit_ent = wr_en && (wr_ent == ENT_W'(e));

    trt_entry #(
      .N_OPND(N_OPND), .DATA_W(DATA_W), .TAG_W(TAG_W), .PID_W(PID_W)
    ) u_ent (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_stat_en(hit_ent && (wr_sel == FLD_STAT)),
      .wr_val_en (hit_ent && (wr_sel == FLD_VAL)),
      .wr_idx    (wr_idx),
      .wr_data   (wr_data),
      .wk_en     (wk_en),
      .wk_tag    (wk_tag),
      .wk_data   (wk_data),
      .all_rdy   (rdy_a[e]),
      .vals      (vals_a[e]),
      .pids      (pids_a[e])
    );
  end

  // slot bookkeeping: claimed, handed to the element, reorder tag
  logic [ENTRIES-1:0]            busy_q, busy_d;
  logic [ENTRIES-1:0]            sent_q, sent_d;
  logic [ENTRIES-1:0][TAG_W-1:0] tag_q;
  logic [ENTRIES-1:0]            cand;
  logic                          pick_vld;
  logic [ENT_W-1:0]              pick_idx;
  logic                          take_now;

  assign take_now = issue_take && pick_vld;

  always_comb begin
    busy_d = busy_q;
    sent_d = sent_q;
    for (int e = 0; e < ENTRIES; e++) begin
      if (done_en && done_entry == ENT_W'(e)) busy_d[e] = 1'b0;
      if (take_now && pick_idx == ENT_W'(e)) sent_d[e] = 1'b1;
      if (alloc_en && alloc_entry == ENT_W'(e)) begin
        busy_d[e] = 1'b1;
        sent_d[e] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= '0;
      sent_q <= '0;
    end else begin
      busy_q <= busy_d;
      sent_q <= sent_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        tag_q <= '0;
    else if (alloc_en) tag_q[alloc_entry] <= alloc_tag;
  end

  assign cand = busy_q & ~sent_q & rdy_a;

  trt_age_pick #(.N(ENTRIES)) u_pick (
    .clk      (clk),
    .rst_n    (rst_n),
    .alloc_en (alloc_en),
    .alloc_idx(alloc_entry),
    .cand     (cand),
    .pick_vld (pick_vld),
    .pick_idx (pick_idx)
  );

  assign issue_vld   = pick_vld;
  assign issue_entry = pick_idx;
  assign issue_tag   = tag_q[pick_idx];
  assign issue_vals  = vals_a[pick_idx];
  assign issue_pids  = pids_a[pick_idx];

  always_comb begin
    free_cnt = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (!busy_q[e]) free_cnt = free_cnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/task_rsv_table_chk.sv
module task_rsv_table_chk #(
  parameter int ENTRIES = 4,
  parameter int ENT_W   = 2,
  parameter int CNT_W   = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic               alloc_en,
  input logic [ENT_W-1:0]   alloc_entry,
  input logic               wk_en,
  input logic               issue_vld,
  input logic [ENT_W-1:0]   issue_entry,
  input logic               issue_take,
  input logic               done_en,
  input logic [ENT_W-1:0]   done_entry,
  input logic [CNT_W-1:0]   free_cnt,
  input logic [ENTRIES-1:0] busy_q
);
  assert_offer_claimed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    issue_vld |-> busy_q[issue_entry]);

  assert_taken_not_reoffered_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_vld && issue_take && !alloc_en)
    |=> !(issue_vld && issue_entry == $past(issue_entry)));

  assert_done_frees_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_en && busy_q[done_entry] && !alloc_en)
    |=> (free_cnt == $past(free_cnt) + 1'b1));

  assert_alloc_claims_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_en && !busy_q[alloc_entry] && !done_en)
    |=> (free_cnt == $past(free_cnt) - 1'b1));

  assert_offer_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_vld && !issue_take && !done_en && !alloc_en && !wr_en && !wk_en)
    |=> (issue_vld && issue_entry == $past(issue_entry)));
endmodule

bind task_rsv_table task_rsv_table_chk #(
  .ENTRIES(ENTRIES), .ENT_W(ENT_W), .CNT_W(CNT_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .alloc_en   (alloc_en),
  .alloc_entry(alloc_entry),
  .wk_en      (wk_en),
  .issue_vld  (issue_vld),
  .issue_entry(issue_entry),
  .issue_take (issue_take),
  .done_en    (done_en),
  .done_entry (done_entry),
  .free_cnt   (free_cnt),
  .busy_q     (busy_q)
);

// File: tb/tb_task_rsv_table.sv
`timescale 1ns/1ps
module tb_task_rsv_table;
  localparam int ENTRIES = 4;
  localparam int N_OPND  = 8;
  localparam int DATA_W  = 32;
  localparam int TAG_W   = 6;
  localparam int PID_W   = 8;

  logic                     clk;
  logic                     rst_n;
  logic                     wr_en;
  logic [5:0]               wr_addr;
  logic [DATA_W-1:0]        wr_data;
  logic                     alloc_en;
  logic [1:0]               alloc_entry;
  logic [TAG_W-1:0]         alloc_tag;
  logic                     wk_en;
  logic [TAG_W-1:0]         wk_tag;
  logic [DATA_W-1:0]        wk_data;
  logic                     issue_vld;
  logic [1:0]               issue_entry;
  logic [TAG_W-1:0]         issue_tag;
  logic [N_OPND*DATA_W-1:0] issue_vals;
  logic [N_OPND*PID_W-1:0]  issue_pids;
  logic                     issue_take;
  logic                     done_en;
  logic [1:0]               done_entry;
  logic [2:0]               free_cnt;

  task_rsv_table dut (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .alloc_en(alloc_en), .alloc_entry(alloc_entry), .alloc_tag(alloc_tag),
    .wk_en(wk_en), .wk_tag(wk_tag), .wk_data(wk_data),
    .issue_vld(issue_vld), .issue_entry(issue_entry), .issue_tag(issue_tag),
    .issue_vals(issue_vals), .issue_pids(issue_pids), .issue_take(issue_take),
    .done_en(done_en), .done_entry(done_entry), .free_cnt(free_cnt)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] word(int k);
    return issue_vals[k*32 +: 32];
  endfunction

  function automatic logic [7:0] pidv(int e, int k);
    return 8'(e * 16 + k);
  endfunction

  // ready operand words: low 6 bits equal the operand index
  function automatic logic [31:0] valv(int e, int k);
    return 32'hA500_0000 | (32'(e) << 8) | 32'(k);
  endfunction

  // every operation starts at a falling edge and returns at the next one
  task automatic wr_stat(int e, int k, logic [7:0] pid, logic rdy);
    wr_en = 1'b1; wr_addr = {2'(e), 1'b0, 3'(k)}; wr_data = {23'd0, pid, rdy};
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wr_val(int e, int k, logic [31:0] v);
    wr_en = 1'b1; wr_addr = {2'(e), 1'b1, 3'(k)}; wr_data = v;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic alloc(int e, logic [5:0] tag);
    alloc_en = 1'b1; alloc_entry = 2'(e); alloc_tag = tag;
    @(negedge clk); alloc_en = 1'b0;
  endtask

  task automatic wake(logic [5:0] tag, logic [31:0] d);
    wk_en = 1'b1; wk_tag = tag; wk_data = d;
    @(negedge clk); wk_en = 1'b0;
  endtask

  task automatic wake_wr(logic [5:0] tag, logic [31:0] d, logic [5:0] a, logic [31:0] wd);
    wk_en = 1'b1; wk_tag = tag; wk_data = d;
    wr_en = 1'b1; wr_addr = a; wr_data = wd;
    @(negedge clk); wk_en = 1'b0; wr_en = 1'b0;
  endtask

  task automatic take();
    issue_take = 1'b1;
    @(negedge clk); issue_take = 1'b0;
  endtask

  task automatic done(int e);
    done_en = 1'b1; done_entry = 2'(e);
    @(negedge clk); done_en = 1'b0;
  endtask

  task automatic fill(int e, logic [7:0] pend, logic [5:0] ptag);
    for (int k = 0; k < N_OPND; k++) begin
      wr_stat(e, k, pidv(e, k), !pend[k]);
      wr_val(e, k, pend[k] ? {26'd0, ptag} : valv(e, k));
    end
  endtask

  task automatic t_reset();
    check("R1", "free_cnt after reset", free_cnt, 4);
    check("R1", "issue_vld after reset", issue_vld, 0);
  endtask

  task automatic t_basic();
    fill(1, 8'h00, 6'd0);
    alloc(1, 6'd5);
    check("R5", "offer when all ready", issue_vld, 1);
    check("R5", "offered slot", issue_entry, 1);
    check("R5", "offered tag", issue_tag, 5);
    check("R3", "word 0", word(0), valv(1, 0));
    check("R3", "word 7", word(7), valv(1, 7));
    check("R2", "pid of operand 3", issue_pids[3*8 +: 8], pidv(1, 3));
    check("R8", "free_cnt after claim", free_cnt, 3);
    take();
    check("R7", "no offer after take", issue_vld, 0);
    done(1);
    check("R8", "free_cnt after done", free_cnt, 4);
  endtask

  task automatic t_wakeup();
    fill(0, 8'b0100_0100, 6'd9);
    wr_val(0, 4, 32'd10);
    wr_stat(0, 4, pidv(0, 4), 1'b0);
    alloc(0, 6'd21);
    check("R5", "waiting slot not offered", issue_vld, 0);
    wake(6'd3, 32'hDEAD_0003);
    wake(6'd9, 32'h5A5A_1234);
    check("R5", "still one operand waiting", issue_vld, 0);
    wake(6'd10, 32'h0BAD_F00D);
    check("R5", "offer cycle after last wake", issue_vld, 1);
    check("R5", "woken slot tag", issue_tag, 21);
    check("R4", "word 2 captured", word(2), 32'h5A5A_1234);
    check("R4", "word 6 captured", word(6), 32'h5A5A_1234);
    check("R4", "word 4 captured", word(4), 32'h0BAD_F00D);
    check("R4", "ready word 3 untouched by tag 3", word(3), valv(0, 3));
    take();
    done(0);
  endtask

  task automatic t_age();
    fill(2, 8'h01, 6'd20);
    alloc(2, 6'd11);
    fill(0, 8'h00, 6'd0);
    alloc(0, 6'd12);
    fill(3, 8'h80, 6'd20);
    alloc(3, 6'd13);
    check("R5", "only ready slot offered", issue_entry, 0);
    @(negedge clk);
    check("R10", "offer held", issue_vld, 1);
    check("R10", "offer held on slot", issue_entry, 0);
    take();
    check("R7", "none left ready", issue_vld, 0);
    wake(6'd20, 32'h1357_9BDF);
    check("R6", "oldest ready offered", issue_entry, 2);
    check("R6", "oldest tag", issue_tag, 11);
    check("R4", "slot 2 word 0", word(0), 32'h1357_9BDF);
    take();
    check("R7", "next slot offered", issue_vld, 1);
    check("R7", "next slot index", issue_entry, 3);
    check("R4", "slot 3 word 7", word(7), 32'h1357_9BDF);
    take();
    check("R7", "all taken", issue_vld, 0);
    check("R8", "free_cnt with three claimed", free_cnt, 1);
    done(0); done(2); done(3);
    check("R8", "free_cnt back to four", free_cnt, 4);
  endtask

  task automatic t_collide();
    fill(1, 8'h20, 6'd30);
    wr_val(1, 6, 32'd31);
    wr_stat(1, 6, pidv(1, 6), 1'b0);
    alloc(1, 6'd7);
    wake_wr(6'd30, 32'hC0DE_0030, {2'd1, 1'b1, 3'd5}, 32'hEEEE_EEEE);
    check("R9", "value write lost to wake", issue_vld, 0);
    wake_wr(6'd31, 32'hC0DE_0031, {2'd1, 1'b0, 3'd6}, {23'd0, 8'h77, 1'b0});
    check("R9", "slot ready after collisions", issue_vld, 1);
    check("R9", "word 5 holds broadcast", word(5), 32'hC0DE_0030);
    check("R9", "word 6 holds broadcast", word(6), 32'hC0DE_0031);
    check("R9", "pid 6 from status write", issue_pids[6*8 +: 8], 8'h77);
    take();
    done(1);
  endtask

  task automatic t_full();
    int order[4] = '{3, 1, 0, 2};
    for (int i = 0; i < 4; i++) begin
      fill(order[i], 8'h00, 6'd0);
      alloc(order[i], 6'(40 + i));
    end
    check("R8", "table full", free_cnt, 0);
    for (int i = 0; i < 4; i++) begin
      check("R6", "full table offer order", issue_entry, order[i]);
      check("R6", "full table tag", issue_tag, 40 + i);
      take();
    end
    check("R7", "nothing left", issue_vld, 0);
    done(2);
    check("R8", "one freed", free_cnt, 1);
    done(0); done(1); done(3);
    check("R8", "all freed", free_cnt, 4);
  endtask

  initial begin
    rst_n = 1'b0;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    alloc_en = 1'b0; alloc_entry = '0; alloc_tag = '0;
    wk_en = 1'b0; wk_tag = '0; wk_data = '0;
    issue_take = 1'b0; done_en = 1'b0; done_entry = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_wakeup();
    t_age();
    t_collide();
    t_full();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL R1 watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule